// File: doc/BRIEF.md
# Converter Configuration Word Register

This block holds the run-time configuration of a dual current-output converter. A host places an 8-bit word on the channel A data bus and pulses an active-low write strobe. The word is captured on the strobe's rising edge, in the strobe's own timing domain. The strobe has no required relationship with the conversion clock, and that clock may keep running through the write.

The captured word is carried into the conversion clock domain by a toggle handshake. All settings update there together on one clock edge. The word is decoded into a three-state operating mode (run, standby, power-down), an interleaved-input enable, an external-reference select and a signed gain trim for channel A.

After the block leaves standby or power-down, it holds its valid flag low for a settling time. That time is counted in conversion clock cycles, and standby and power-down each have their own count. The analog reference, current steering and gain scaling are outside this block.

Top module: `dac_cfg_reg`

## Requirements
- R1: After reset the outputs are: mode_o = 00 (run), ilv_o = 0, ext_ref_o = 0, gain_o = 0 (gain code 1000) and valid_o = 1.
- R2: The word is sampled from data_i on the rising edge of wr_ni. Bit 7 is power-down, bit 6 is converter enable, bit 5 is interleave, bit 4 is external reference, and bits 3:0 are the gain code.
- R3: Bit 7 = 1 selects power-down (mode_o = 10), whatever the values of the other bits.
- R4: Bit 7 = 0 with bit 6 = 0 selects standby (mode_o = 01).
- R5: Bit 7 = 0 with bit 6 = 1 selects run (mode_o = 00).
- R6: gain_o is a 5-bit signed value equal to 8 minus the gain code: +8 for code 0000, 0 for code 1000, -7 for code 1111. Each count is 0.05 dB.
- R7: ilv_o follows bit 5 and ext_ref_o follows bit 4 of the last word written.
- R8: All fields of a new word appear on the outputs together, no later than 4 conversion clock edges after the strobe's rising edge.
- R9: valid_o is 0 whenever mode_o is standby or power-down.
- R10: When the mode goes from standby to run, valid_o rises exactly STBY_WAKE_CYC clock edges after mode_o first shows run.
- R11: When the mode goes from power-down to run, valid_o rises exactly OFF_WAKE_CYC clock edges after mode_o first shows run.
- R12: Writing a run word while the block is already running and valid leaves valid_o high.
- R13: Changes on data_i with no rising edge on wr_ni leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_ni | input | 1 | Active-low write strobe; the word is taken on its rising edge |
| data_i | input | 8 | Shared channel A data bus carrying the configuration word |
| mode_o | output | 2 | Operating mode: 00 run, 01 standby, 10 power-down |
| ilv_o | output | 1 | Interleaved input enable |
| ext_ref_o | output | 1 | External reference selected |
| gain_o | output | 5 | Signed channel A gain trim in 0.05 dB counts |
| valid_o | output | 1 | Converter outputs settled and usable |

## Verification
A fault in the strobe-domain holding register or in the handshake shows up within four clock edges of a write: stale fields, or fields that are only partly updated, appear on mode_o, ilv_o, ext_ref_o and gain_o. A wrong mode decode or wrong priority shows directly as a wrong mode_o code. A fault in the settling counter shows only later: valid_o rises too early or too late after a return to run, so the bench measures that interval in clock edges for both standby and power-down. It also checks that a repeated run write does not drop valid_o.

// File: rtl/dacctl_pkg.sv
package dacctl_pkg;
  localparam int WORD_W = 8;
  localparam int GAIN_W = 4;
  localparam int TRIM_W = GAIN_W + 1;

  localparam int BIT_OFF = 7;
  localparam int BIT_EN  = 6;
  localparam int BIT_ILV = 5;
  localparam int BIT_EXT = 4;

  localparam logic [GAIN_W-1:0] GAIN_ZERO = 4'b1000;
  localparam logic [WORD_W-1:0] WORD_RST  = {1'b0, 1'b1, 1'b0, 1'b0, GAIN_ZERO};

  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_STBY = 2'b01,
    MODE_OFF  = 2'b10
  } mode_e;
endpackage

// File: rtl/cw_capture.sv
module cw_capture
  import dacctl_pkg::*;
(
  input  logic              wr_ni,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o,
  output logic              tog_o
);
  // strobe domain: word held until the next write
  always_ff @(posedge wr_ni or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= WORD_RST;
      tog_o  <= 1'b0;
    end else begin
      word_o <= data_i;
      tog_o  <= ~tog_o;
    end
  end
endmodule

// File: rtl/cw_sync.sv
module cw_sync
  import dacctl_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              tog_i,
  output logic [WORD_W-1:0] word_o
);
  logic [STAGES-1:0] sync_q;
  logic              seen_q;
  logic              load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], tog_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= sync_q[STAGES-1];
  end

  assign load = sync_q[STAGES-1] ^ seen_q;

  // word_i has been stable for STAGES cycles when load fires
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_o <= WORD_RST;
    else if (load) word_o <= word_i;
  end

  p_word_atomic_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(word_o));
endmodule

// File: rtl/cw_decode.sv
module cw_decode
  import dacctl_pkg::*;
(
  input  logic [WORD_W-1:0]        word_i,
  output mode_e                    mode_o,
  output logic                     ilv_o,
  output logic                     ext_ref_o,
  output logic signed [TRIM_W-1:0] gain_o
);
  always_comb begin
    if (word_i[BIT_OFF])     mode_o = MODE_OFF;
    else if (!word_i[BIT_EN]) mode_o = MODE_STBY;
    else                     mode_o = MODE_RUN;
  end

  assign ilv_o     = word_i[BIT_ILV];
  assign ext_ref_o = word_i[BIT_EXT];
  assign gain_o    = $signed({1'b0, GAIN_ZERO}) - $signed({1'b0, word_i[GAIN_W-1:0]});
endmodule

// File: rtl/wake_timer.sv
module wake_timer
  import dacctl_pkg::*;
#(
  parameter int STBY_WAKE_CYC = 240,
  parameter int OFF_WAKE_CYC  = 40000
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  output logic  valid_o
);
  localparam int CNT_W = $clog2(OFF_WAKE_CYC + 1);
  localparam logic [CNT_W-1:0] STBY_LD = CNT_W'(STBY_WAKE_CYC - 1);
  localparam logic [CNT_W-1:0] OFF_LD  = CNT_W'(OFF_WAKE_CYC - 1);

  mode_e            prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_now, run_prev;

  assign run_now  = (mode_i == MODE_RUN);
  assign run_prev = (prev_q == MODE_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= MODE_RUN;
      cnt_q  <= '0;
    end else begin
      prev_q <= mode_i;
      if (!run_now)             cnt_q <= '0;
      else if (!run_prev)       cnt_q <= (prev_q == MODE_OFF) ? OFF_LD : STBY_LD;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end
  end

  assign valid_o = run_now && run_prev && (cnt_q == '0);

  p_valid_run_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (mode_i == MODE_RUN));
  p_wake_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_now && !run_prev) |-> !valid_o);
  p_cnt_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(OFF_WAKE_CYC));
  p_valid_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> (valid_o || mode_i != MODE_RUN));
endmodule

// File: rtl/dac_cfg_reg.sv
module dac_cfg_reg
  import dacctl_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int STBY_WAKE_CYC = 240,
  parameter int OFF_WAKE_CYC  = 40000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_ni,
  input  logic [7:0]               data_i,
  output logic [1:0]               mode_o,
  output logic                     ilv_o,
  output logic                     ext_ref_o,
  output logic signed [4:0]        gain_o,
  output logic                     valid_o
);
  logic [WORD_W-1:0] word_wr, word_clk;
  logic              tog_wr;
  mode_e             mode;

  cw_capture u_capture (
    .wr_ni  (wr_ni),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .word_o (word_wr),
    .tog_o  (tog_wr)
  );

  cw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .word_i (word_wr),
    .tog_i  (tog_wr),
    .word_o (word_clk)
  );

  cw_decode u_decode (
    .word_i    (word_clk),
    .mode_o    (mode),
    .ilv_o     (ilv_o),
    .ext_ref_o (ext_ref_o),
    .gain_o    (gain_o)
  );

  wake_timer #(
    .STBY_WAKE_CYC (STBY_WAKE_CYC),
    .OFF_WAKE_CYC  (OFF_WAKE_CYC)
  ) u_wake (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .valid_o (valid_o)
  );

  assign mode_o = mode;

  p_mode_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11);
endmodule

// File: tb/dac_cfg_reg_tb.sv
module dac_cfg_reg_tb;
  localparam int STBY_W = 12;
  localparam int OFF_W  = 40;
  localparam int NVEC   = 9;

  logic clk_i = 1'b0, rst_ni = 1'b0, wr_ni = 1'b1;
  logic [7:0] data_i = 8'h00;
  logic [1:0] mode_o;
  logic ilv_o, ext_ref_o, valid_o;
  logic signed [4:0] gain_o;
  int total = 0, bad = 0;

  always #2 clk_i = ~clk_i;

  dac_cfg_reg #(.STBY_WAKE_CYC(STBY_W), .OFF_WAKE_CYC(OFF_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_ni(wr_ni), .data_i(data_i),
    .mode_o(mode_o), .ilv_o(ilv_o), .ext_ref_o(ext_ref_o),
    .gain_o(gain_o), .valid_o(valid_o)
  );

  // {word, mode, ilv, ext, gain}
  localparam logic [16:0] VEC [NVEC] = '{
    {8'h48, 2'b00, 1'b0, 1'b0, 5'sd0},
    {8'h60, 2'b00, 1'b1, 1'b0, 5'sd8},
    {8'h5F, 2'b00, 1'b0, 1'b1, -5'sd7},
    {8'h7A, 2'b00, 1'b1, 1'b1, -5'sd2},
    {8'h03, 2'b01, 1'b0, 1'b0, 5'sd5},
    {8'hC8, 2'b10, 1'b0, 1'b0, 5'sd0},
    {8'h8F, 2'b10, 1'b0, 1'b0, -5'sd7},
    {8'hB1, 2'b10, 1'b1, 1'b1, 5'sd7},
    {8'h44, 2'b00, 1'b0, 1'b0, 5'sd4}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [7:0] w);
    @(negedge clk_i);
    #1 data_i = w;
    #1 wr_ni = 1'b0;
    #5 wr_ni = 1'b1;
    #1 data_i = ~w;
  endtask

  task automatic write_settle(input logic [7:0] w);
    strobe(w);
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wake_measure(input logic [7:0] w, input int exp, input string req);
    int n0 = -1, n = 0;
    strobe(w);
    while (n < 200) begin
      @(negedge clk_i);
      if (n0 < 0 && mode_o == 2'b00) n0 = n;
      if (n0 >= 0 && valid_o) break;
      n++;
    end
    chk(req, n - n0, exp);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 mode", mode_o, 0);
    chk("R1 ilv", ilv_o, 0);
    chk("R1 ext", ext_ref_o, 0);
    chk("R1 gain", gain_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 valid", valid_o, 1);

    // R2 R3 R4 R5 R6 R7 R8 R9 table walk
    for (int i = 0; i < NVEC; i++) begin
      write_settle(VEC[i][16:9]);
      chk("R3/R4/R5 mode", mode_o, VEC[i][8:7]);
      chk("R7 ilv", ilv_o, VEC[i][6]);
      chk("R7 ext", ext_ref_o, VEC[i][5]);
      chk("R6 gain", gain_o, $signed(VEC[i][4:0]));
      if (VEC[i][8:7] != 2'b00) chk("R9 valid", valid_o, 0);
    end

    // R10 standby to run
    write_settle(8'h08);
    chk("R4 standby", mode_o, 1);
    wake_measure(8'h48, STBY_W, "R10 wake");

    // R11 power-down to run
    write_settle(8'hC8);
    chk("R9 off valid", valid_o, 0);
    wake_measure(8'h48, OFF_W, "R11 wake");

    // R12 run rewrite keeps valid
    repeat (5) @(negedge clk_i);
    strobe(8'h4C);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i);
      if (!valid_o) chk("R12 valid held", 0, 1);
    end
    chk("R12 valid", valid_o, 1);
    chk("R6 code 1100", gain_o, -4);

    // R13 bus activity without a strobe edge
    data_i = 8'hFF;
    repeat (6) @(negedge clk_i);
    data_i = 8'h80;
    repeat (6) @(negedge clk_i);
    chk("R13 mode", mode_o, 0);
    chk("R13 gain", gain_o, -4);
    chk("R13 valid", valid_o, 1);

    // R2 R8 MSB priority with all bits set
    write_settle(8'hFF);
    chk("R3 all ones", mode_o, 2);
    chk("R8 gain", gain_o, -7);
    chk("R8 ilv", ilv_o, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule